// File: doc/BRIEF.md
# Inter-Core Doorbell Message Unit

This block keeps, for each of N cores, two sticky pending-interrupt flags: a normal doorbell flag and a critical doorbell flag. A send command carries a 32-bit message word. The word holds three fields:

- a message type,
- a broadcast flag,
- a target identifier tag.

A send sets the matching flag in every core whose identifier equals the tag. When the broadcast flag is set, it sets the flag in all cores. A clear command names the core that issues it and carries a message word of the same layout. It drops the matching flag in that one core only. The tag and broadcast fields of a clear have no effect.

Each core's identifier is a register that takes its value at reset from a parameter. Two identical identifiers are allowed, and then one send reaches both cores. Each core's interrupt-request output is the OR of its two flags. So a core that is addressed by a send raises its request on the next clock.

Each flag is a two-state machine with these states and transitions:

- States: `BELL_IDLE` and `BELL_PEND`.
- `BELL_IDLE` to `BELL_PEND`, taken on a set.
- `BELL_PEND` to `BELL_IDLE`, taken on a clear with no set.
- `BELL_PEND` stays in `BELL_PEND` otherwise.
- `BELL_IDLE` stays in `BELL_IDLE` otherwise.

Top module: `bell_msg_hub`

## Requirements
- R1: After reset every pending flag and every `irq_req` bit is 0.
- R2: The message type is in word bits [31:27]. Type 0 selects the normal doorbell flag (`pend_bell`). Type 1 selects the critical doorbell flag (`pend_crit`).
- R3: Types 2, 3 and 4 (the guest normal, guest critical and guest machine-check doorbells) and every type from 5 to 31 select no flag. A send or a clear with such a type changes nothing.
- R4: A send without broadcast sets the selected flag in every core whose identifier equals word bits [13:0], and in no other core.
- R5: A send with word bit 26 set sets the selected flag in all cores, whatever the tag.
- R6: A clear drops the selected flag only in the core given by `clr_src`. Its tag and broadcast fields are ignored.
- R7: When a send and a clear reach the same flag of the same core in one cycle, the flag ends up set.
- R8: A flag stays set until a clear reaches it. `irq_req[i]` equals `pend_bell[i] | pend_crit[i]`.
- R9: A command takes effect at the clock edge that samples it. The outputs are unchanged before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | 1 | Send command present |
| snd_word | input | 32 | Send message word |
| clr_valid | input | 1 | Clear command present |
| clr_src | input | SRC_W | Index of the core issuing the clear |
| clr_word | input | 32 | Clear message word |
| pend_bell | output | NUM_CORES | Normal doorbell pending flags, one per core |
| pend_crit | output | NUM_CORES | Critical doorbell pending flags, one per core |
| irq_req | output | NUM_CORES | Interrupt request per core |

## Verification
Every flag state is a port, so a wrong state shows at the next clock edge after the command that produced it.

- A flag stuck in `BELL_PEND` shows up at the first clear that fails to drop it.
- A wrong identifier compare shows up as a core that lights, or stays dark, in the cycle after the send.
- A bad type decode shows up the same way, as the wrong core or flag changing.

The directed tests compare all three output vectors after every command. This also catches a change made to a core that was not addressed.

// File: rtl/bell_pkg.sv
package bell_pkg;
    localparam int WORD_W  = 32;
    localparam int TYPE_HI = 31;
    localparam int TYPE_LO = 27;
    localparam int BCAST_B = 26;
    localparam int NUM_CLS = 2;
    localparam int CLS_BELL = 0;
    localparam int CLS_CRIT = 1;

    typedef enum logic [4:0] {
        MSG_PLAIN   = 5'd0,
        MSG_CRIT    = 5'd1,
        MSG_G_PLAIN = 5'd2,
        MSG_G_CRIT  = 5'd3,
        MSG_G_MCHK  = 5'd4
    } msg_type_e;

    typedef enum logic {
        BELL_IDLE = 1'b0,
        BELL_PEND = 1'b1
    } bell_st_e;
endpackage

// File: rtl/bell_decode.sv
module bell_decode
    import bell_pkg::*;
#(
    parameter int TAG_W = 14
) (
    input  logic [WORD_W-1:0]  word_i,
    output logic [NUM_CLS-1:0] cls_o,
    output logic               bcast_o,
    output logic [TAG_W-1:0]   tag_o
);
    logic [4:0] kind;

    assign kind    = word_i[TYPE_HI:TYPE_LO];
    assign bcast_o = word_i[BCAST_B];
    assign tag_o   = word_i[TAG_W-1:0];

    always_comb begin
        cls_o = '0;
        unique case (kind)
            MSG_PLAIN: cls_o[CLS_BELL] = 1'b1;
            MSG_CRIT:  cls_o[CLS_CRIT] = 1'b1;
            default:   cls_o = '0;
        endcase
    end
endmodule

// File: rtl/bell_bit_fsm.sv
module bell_bit_fsm
    import bell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    bell_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BELL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BELL_IDLE: if (set_i)               state_d = BELL_PEND;
            BELL_PEND: if (clr_i && !set_i)     state_d = BELL_IDLE;
            default:                            state_d = BELL_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == BELL_PEND);
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);
    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);
    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o);
    // R3
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !set_i) |=> !pend_o);
endmodule

// File: rtl/bell_core_slot.sv
module bell_core_slot
    import bell_pkg::*;
#(
    parameter int              TAG_W    = 14,
    parameter int              SRC_W    = 2,
    parameter int              IDX      = 0,
    parameter logic [TAG_W-1:0] RESET_ID = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               snd_valid,
    input  logic [NUM_CLS-1:0] snd_cls,
    input  logic               snd_bcast,
    input  logic [TAG_W-1:0]   snd_tag,
    input  logic               clr_valid,
    input  logic [SRC_W-1:0]   clr_src,
    input  logic [NUM_CLS-1:0] clr_cls,
    output logic [NUM_CLS-1:0] pend_o,
    output logic               irq_o
);
    localparam logic [SRC_W-1:0] MY_IDX = SRC_W'(IDX);

    logic [TAG_W-1:0] id_q;
    logic             addressed;
    logic             clr_mine;

    always_ff @(posedge clk) begin
        if (!rst_n) id_q <= RESET_ID;
    end

    assign addressed = snd_valid && (snd_bcast || (snd_tag == id_q));
    assign clr_mine  = clr_valid && (clr_src == MY_IDX);

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        bell_bit_fsm u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (addressed && snd_cls[c]),
            .clr_i  (clr_mine && clr_cls[c]),
            .pend_o (pend_o[c])
        );
    end

    assign irq_o = |pend_o;

    // R4
    rise_needs_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(addressed));
    // R6
    foreign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o != '0 && !clr_mine) |=> (pend_o != '0));
endmodule

// File: rtl/bell_msg_hub.sv
module bell_msg_hub
    import bell_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int TAG_W     = 14,
    parameter int SRC_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    parameter logic [NUM_CORES*TAG_W-1:0] CORE_IDS =
        {14'h011, 14'h012, 14'h011, 14'h010}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 snd_valid,
    input  logic [31:0]          snd_word,
    input  logic                 clr_valid,
    input  logic [SRC_W-1:0]     clr_src,
    input  logic [31:0]          clr_word,
    output logic [NUM_CORES-1:0] pend_bell,
    output logic [NUM_CORES-1:0] pend_crit,
    output logic [NUM_CORES-1:0] irq_req
);
    logic [NUM_CLS-1:0] snd_cls, clr_cls;
    logic               snd_bcast, clr_bcast_unused;
    logic [TAG_W-1:0]   snd_tag, clr_tag_unused;

    bell_decode #(.TAG_W(TAG_W)) u_snd_dec (
        .word_i (snd_word),
        .cls_o  (snd_cls),
        .bcast_o(snd_bcast),
        .tag_o  (snd_tag)
    );

    bell_decode #(.TAG_W(TAG_W)) u_clr_dec (
        .word_i (clr_word),
        .cls_o  (clr_cls),
        .bcast_o(clr_bcast_unused),
        .tag_o  (clr_tag_unused)
    );

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        logic [NUM_CLS-1:0] pend;
        bell_core_slot #(
            .TAG_W   (TAG_W),
            .SRC_W   (SRC_W),
            .IDX     (i),
            .RESET_ID(CORE_IDS[i*TAG_W +: TAG_W])
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .snd_valid(snd_valid),
            .snd_cls  (snd_cls),
            .snd_bcast(snd_bcast),
            .snd_tag  (snd_tag),
            .clr_valid(clr_valid),
            .clr_src  (clr_src),
            .clr_cls  (clr_cls),
            .pend_o   (pend),
            .irq_o    (irq_req[i])
        );
        assign pend_bell[i] = pend[CLS_BELL];
        assign pend_crit[i] = pend[CLS_CRIT];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pend_bell == '0 && pend_crit == '0));
    // R3
    guest_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_valid && snd_valid && snd_word[31:27] > 5'd1)
            |=> ($stable(pend_bell) && $stable(pend_crit)));
    // R5
    bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && snd_word[26] && snd_word[31:27] == 5'd0)
            |=> (pend_bell == {NUM_CORES{1'b1}}));
endmodule

// File: tb/tb_bell_msg_hub.sv
module tb_bell_msg_hub;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam logic [13:0] IDS [N] = '{14'h010, 14'h011, 14'h012, 14'h011};

    logic clk = 0, rst_n = 0;
    logic snd_valid = 0, clr_valid = 0;
    logic [31:0] snd_word = 0, clr_word = 0;
    logic [1:0] clr_src = 0;
    logic [N-1:0] pend_bell, pend_crit, irq_req;
    logic [N-1:0] exp_b = 0, exp_c = 0;
    int errors = 0, checks = 0;
    bit done = 0;

    bell_msg_hub dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(input logic [4:0] t, input logic bc, input logic [13:0] tag);
        return {t, bc, 12'h0, tag};
    endfunction

    task automatic check(input string req);
        checks++;
        if (pend_bell !== exp_b || pend_crit !== exp_c || irq_req !== (exp_b | exp_c)) begin
            errors++;
            $display("FAIL %s: bell=%b crit=%b irq=%b expected bell=%b crit=%b irq=%b",
                     req, pend_bell, pend_crit, irq_req, exp_b, exp_c, exp_b | exp_c);
        end
    endtask

    // one command cycle; model follows the requirements
    task automatic apply(input logic sv, input logic [31:0] sw,
                         input logic cv, input logic [1:0] cs, input logic [31:0] cw,
                         input string req);
        @(negedge clk);
        snd_valid = sv; snd_word = sw; clr_valid = cv; clr_src = cs; clr_word = cw;
        #1 check({req, " (before edge, R9)"});
        for (int i = 0; i < N; i++) begin
            logic hit, sb, sc, cb, cc;
            hit = sv && (sw[26] || sw[13:0] == IDS[i]);
            sb = hit && sw[31:27] == 5'd0;
            sc = hit && sw[31:27] == 5'd1;
            cb = cv && cs == i[1:0] && cw[31:27] == 5'd0;
            cc = cv && cs == i[1:0] && cw[31:27] == 5'd1;
            exp_b[i] = sb | (exp_b[i] & ~cb);
            exp_c[i] = sc | (exp_c[i] & ~cc);
        end
        @(posedge clk); #1;
        snd_valid = 0; clr_valid = 0;
        check(req);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 check("R1 reset");
        @(negedge clk) rst_n = 1;
        @(posedge clk); #1 check("R1 after release");
    endtask

    task automatic t_tag();
        apply(1, mk(5'd0, 0, 14'h011), 0, 0, 0, "R2 R4 plain to tag 011");
        apply(1, mk(5'd1, 0, 14'h010), 0, 0, 0, "R2 R4 crit to tag 010");
        apply(1, mk(5'd0, 0, 14'h3ff), 0, 0, 0, "R4 unmatched tag");
    endtask

    task automatic t_bcast();
        apply(1, mk(5'd1, 1, 14'h3ff), 0, 0, 0, "R5 crit broadcast");
    endtask

    task automatic t_guest();
        apply(1, mk(5'd2, 1, 14'h0), 0, 0, 0, "R3 guest plain send");
        apply(1, mk(5'd3, 0, 14'h012), 0, 0, 0, "R3 guest crit send");
        apply(1, mk(5'd4, 1, 14'h0), 0, 0, 0, "R3 guest mchk send");
        apply(1, mk(5'd31, 1, 14'h0), 0, 0, 0, "R3 unknown send");
        apply(0, 0, 1, 2'd1, mk(5'd3, 0, 0), "R3 guest crit clear");
        apply(0, 0, 1, 2'd1, mk(5'd9, 0, 0), "R3 unknown clear");
    endtask

    task automatic t_clear();
        apply(0, 0, 1, 2'd1, mk(5'd0, 1, 14'h010), "R6 clear core1 bell, tag/bcast ignored");
        apply(0, 0, 1, 2'd0, mk(5'd1, 0, 14'h011), "R6 clear core0 crit");
    endtask

    task automatic t_sticky();
        repeat (5) @(posedge clk);
        #1 check("R8 sticky idle");
    endtask

    task automatic t_race();
        apply(1, mk(5'd0, 0, 14'h011), 1, 2'd3, mk(5'd0, 0, 0), "R7 send beats clear core3");
        apply(1, mk(5'd0, 0, 14'h010), 1, 2'd2, mk(5'd1, 0, 0), "R7 independent send and clear");
        apply(0, 0, 1, 2'd3, mk(5'd0, 0, 0), "R8 clear core3 bell leaves crit");
        apply(0, 0, 1, 2'd3, mk(5'd1, 0, 0), "R8 clear core3 crit drops irq");
    endtask

    initial begin
        t_reset();
        t_tag();
        t_bcast();
        t_guest();
        t_clear();
        t_sticky();
        t_race();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule